// File: doc/BRIEF.md
# Debug Scan to Memory Bus Access Engine

This block sits behind a JTAG test access port. It turns the values the host scans into the data register into single-word accesses on a simple memory bus. When the port captures a register, the block hands back three status flags: busy, error and protected. The TAP state machine and the shifting of bits both stay outside the block. It receives one-cycle capture and update strobes, the instruction currently selected, and the value the host has just shifted in. It returns the values to be shifted out.

A host first performs an address scan. This scan carries the target address, the transfer size, an auto-increment flag and a read flag. After that, repeated data scans move data.

- A data update in read mode launches the next read.
- A data update in write mode writes the shifted word.
- A data capture returns the most recent read result.

With auto-increment set, the address advances by the transfer size after every completed bus access (block transfer). With it clear, every access reuses the same address (stream transfer). A cancel instruction lets the host poll and abort an access that is hung. A lock input from the flash-security logic stops all bus traffic while the device is locked.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After reset the error flag is 1, the busy flag is 0 and no bus request is active.
- R2: Every IR and DR capture places busy at bit 0, error at bit 1 and protected at bit 2. A DR capture carries the data field at bits [DATA_W+2:3]. The data field is zero unless the instruction is the data scan (code 2).
- R3: An address update (instruction code 1; bit 0 read flag, bits 2:1 size, bit 3 auto-increment, bits [ADDR_W+3:4] address) with the read flag set starts a read at that address and clears the error flag. With the read flag clear, it starts no bus access and leaves the error flag unchanged.
- R4: A DR capture taken while an access is outstanding returns busy=1 and a zero data field, and leaves the access running.
- R5: A data update that arrives while busy is discarded. The bus address and write data do not change, and no extra access is made.
- R6: On completion the error flag takes the bus error response. A failed read leaves zero in the read-data register.
- R7: An address or data update is accepted and starts its access even when the error flag is set.
- R8: With auto-increment set, the address advances by 1 << size after each completed bus access. With it clear, the address does not change.
- R9: A data update (code 2) starts a read when the last address scan had the read flag set. Otherwise it starts a write of the low DATA_W bits of the shifted value.
- R10: The protected flag reflects the lock input at capture. An access started while locked issues no bus request and completes one cycle later with the error flag set.
- R11: A DR capture under the cancel instruction (code 3) while busy drops the request and sets the error flag. If the bus completes in that same cycle, the cancel wins: no read data is latched and the address does not advance.
- R12: Once a request is raised, it stays high with a stable address and write data until the bus completes or a cancel occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 2 | Selected instruction: 0 none, 1 address, 2 data, 3 cancel |
| ir_capture | input | 1 | Capture-IR strobe |
| dr_capture | input | 1 | Capture-DR strobe |
| dr_update | input | 1 | Update-DR strobe |
| dr_upd_val | input | UPD_W | Value shifted in by the host |
| flash_locked | input | 1 | Device locked by the flash-security logic |
| ir_cap_val | output | IR_W | Value to shift out of IR (status in low bits) |
| dr_cap_val | output | CAP_W | Value to shift out of DR ({data, status}) |
| bus_req | output | 1 | Bus request, held until done |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_size | output | 2 | Transfer size, log2 of bytes |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| bus_done | input | 1 | Access complete |
| bus_err | input | 1 | Access failed, valid with done |

## Verification
The race that matters is a cancel poll that lands in the same cycle as the bus completion it is meant to abort. The bench sets the bus model to a two-cycle latency and issues the cancel capture exactly on the completion edge. It then checks three things:

- The captured status still shows busy.
- The following capture shows the error flag set and the earlier read data unchanged.
- A fresh block read goes to the un-incremented address.

A second overlap, an update strobe that arrives while an access is in flight, is provoked with a long latency. It is judged by the write count and the written data.

// File: rtl/dbg_bus_pkg.sv
package dbg_bus_pkg;

    // Instruction codes seen from the TAP
    typedef enum logic [1:0] {
        INS_NONE   = 2'd0,
        INS_ADDR   = 2'd1,
        INS_DATA   = 2'd2,
        INS_CANCEL = 2'd3
    } instr_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_PROT = 2'd2
    } acc_st_e;

    // Status flags, busy in the lowest bit
    typedef struct packed {
        logic prot;
        logic err;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic ld_addr;
        logic start_rd;
        logic start_wr;
        logic cancel;
    } scan_cmd_t;

    localparam int STAT_W   = 3;
    localparam int ADDR_LSB = 4;   // address field start in an address scan

    function automatic logic [3:0] size_step(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    function automatic int unsigned upd_width(input int unsigned aw, input int unsigned dw);
        return (aw + ADDR_LSB > dw) ? aw + ADDR_LSB : dw;
    endfunction

endpackage

// File: rtl/dbg_scan_decode.sv
module dbg_scan_decode
    import dbg_bus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int UPD_W  = 36
) (
    input  logic [1:0]        instr,
    input  logic              dr_update,
    input  logic              dr_capture,
    input  logic [UPD_W-1:0]  upd_val,
    input  logic              last_rd,
    input  logic              busy,
    output scan_cmd_t         cmd,
    output logic [ADDR_W-1:0] new_addr,
    output logic [1:0]        new_size,
    output logic              new_rd,
    output logic              new_inc,
    output logic [DATA_W-1:0] new_wdata
);

    instr_e ins;
    logic   data_upd;

    assign ins      = instr_e'(instr);
    assign data_upd = dr_update && !busy && (ins == INS_DATA);

    always_comb begin
        new_addr     = upd_val[ADDR_LSB +: ADDR_W];
        new_inc      = upd_val[3];
        new_size     = upd_val[2:1];
        new_rd       = upd_val[0];
        new_wdata    = upd_val[DATA_W-1:0];
        cmd.ld_addr  = dr_update && !busy && (ins == INS_ADDR);
        cmd.start_rd = (cmd.ld_addr && upd_val[0]) || (data_upd && last_rd);
        cmd.start_wr = data_upd && !last_rd;
        cmd.cancel   = dr_capture && busy && (ins == INS_CANCEL);
    end

endmodule

// File: rtl/dbg_access_fsm.sv
module dbg_access_fsm
    import dbg_bus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_cmd_t         cmd,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [1:0]        new_size,
    input  logic              new_rd,
    input  logic              new_inc,
    input  logic [DATA_W-1:0] new_wdata,
    input  logic              locked,
    input  logic              bus_done,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              last_rd,
    output logic              err,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    acc_st_e           st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        size_q;
    logic              rd_q;
    logic              inc_q;
    logic              err_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              start;

    assign start = cmd.start_rd || cmd.start_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            size_q  <= '0;
            rd_q    <= 1'b0;
            inc_q   <= 1'b0;
            err_q   <= 1'b1;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (cmd.ld_addr) begin
                addr_q <= new_addr;
                size_q <= new_size;
                rd_q   <= new_rd;
                inc_q  <= new_inc;
            end
            if (cmd.start_wr) begin
                wdata_q <= new_wdata;
            end
            unique case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= 1'b0;
                        st_q  <= locked ? ST_PROT : ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (cmd.cancel) begin
                        st_q  <= ST_IDLE;
                        err_q <= 1'b1;
                    end else if (bus_done) begin
                        st_q  <= ST_IDLE;
                        err_q <= bus_err;
                        if (rd_q) begin
                            rdata_q <= bus_err ? '0 : bus_rdata;
                        end
                        if (inc_q) begin
                            addr_q <= addr_q + ADDR_W'(size_step(size_q));
                        end
                    end
                end
                ST_PROT: begin
                    st_q  <= ST_IDLE;
                    err_q <= 1'b1;
                    if (rd_q) begin
                        rdata_q <= '0;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign last_rd   = rd_q;
    assign err       = err_q;
    assign rdata     = rdata_q;
    assign bus_req   = (st_q == ST_BUS);
    assign bus_we    = !rd_q;
    assign bus_size  = size_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    // R12: request held with stable address and data
    p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_done && !cmd.cancel) |=>
            (bus_req && $stable(bus_addr) && $stable(bus_wdata)));

    // R3: starting an access clears the error flag
    p_err_clear_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> !err_q);

    // R10: locked start never reaches the bus and fails one cycle later
    p_locked_fail_r10: assert property (@(posedge clk) disable iff (rst)
        (start && locked) |=> (!bus_req ##1 (err_q && !busy)));

    // R11: cancel drops the request and flags an error
    p_cancel_r11: assert property (@(posedge clk) disable iff (rst)
        cmd.cancel |=> (!bus_req && err_q));

endmodule

// File: rtl/dbg_capture.sv
module dbg_capture
    import dbg_bus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IR_W   = 5,
    parameter int CAP_W  = DATA_W + STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        instr,
    input  logic              ir_capture,
    input  logic              dr_capture,
    input  stat_t             stat,
    input  logic [DATA_W-1:0] rdata,
    output logic [IR_W-1:0]   ir_cap_val,
    output logic [CAP_W-1:0]  dr_cap_val
);

    logic [IR_W-1:0]   ir_q;
    logic [CAP_W-1:0]  dr_q;
    logic [DATA_W-1:0] data_sel;

    assign data_sel = (!stat.busy && (instr_e'(instr) == INS_DATA)) ? rdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q <= '0;
            dr_q <= '0;
        end else begin
            if (ir_capture) begin
                ir_q <= IR_W'(stat);
            end
            if (dr_capture) begin
                dr_q <= {data_sel, stat};
            end
        end
    end

    assign ir_cap_val = ir_q;
    assign dr_cap_val = dr_q;

    // R4: busy capture returns an invalid (zero) data field
    p_busy_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (dr_capture && stat.busy) |=> (dr_q[CAP_W-1:STAT_W] == '0 && dr_q[0]));

endmodule

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge
    import dbg_bus_pkg::*;
#(
    parameter int  ADDR_W = 32,
    parameter int  DATA_W = 32,
    parameter int  IR_W   = 5,
    localparam int CAP_W  = DATA_W + STAT_W,
    localparam int UPD_W  = int'(upd_width(ADDR_W, DATA_W))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        instr,
    input  logic              ir_capture,
    input  logic              dr_capture,
    input  logic              dr_update,
    input  logic [UPD_W-1:0]  dr_upd_val,
    input  logic              flash_locked,
    output logic [IR_W-1:0]   ir_cap_val,
    output logic [CAP_W-1:0]  dr_cap_val,
    output logic              bus_req,
    output logic              bus_we,
    output logic [1:0]        bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_done,
    input  logic              bus_err
);

    scan_cmd_t         cmd;
    logic [ADDR_W-1:0] new_addr;
    logic [1:0]        new_size;
    logic              new_rd;
    logic              new_inc;
    logic [DATA_W-1:0] new_wdata;
    logic              busy;
    logic              last_rd;
    logic              err;
    logic [DATA_W-1:0] rdata;
    stat_t             stat;

    dbg_scan_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UPD_W(UPD_W)) u_decode (
        .instr     (instr),
        .dr_update (dr_update),
        .dr_capture(dr_capture),
        .upd_val   (dr_upd_val),
        .last_rd   (last_rd),
        .busy      (busy),
        .cmd       (cmd),
        .new_addr  (new_addr),
        .new_size  (new_size),
        .new_rd    (new_rd),
        .new_inc   (new_inc),
        .new_wdata (new_wdata)
    );

    dbg_access_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .new_addr (new_addr),
        .new_size (new_size),
        .new_rd   (new_rd),
        .new_inc  (new_inc),
        .new_wdata(new_wdata),
        .locked   (flash_locked),
        .bus_done (bus_done),
        .bus_err  (bus_err),
        .bus_rdata(bus_rdata),
        .busy     (busy),
        .last_rd  (last_rd),
        .err      (err),
        .rdata    (rdata),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata)
    );

    assign stat = '{prot: flash_locked, err: err, busy: busy};

    dbg_capture #(.DATA_W(DATA_W), .IR_W(IR_W), .CAP_W(CAP_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .instr     (instr),
        .ir_capture(ir_capture),
        .dr_capture(dr_capture),
        .stat      (stat),
        .rdata     (rdata),
        .ir_cap_val(ir_cap_val),
        .dr_cap_val(dr_cap_val)
    );

    // R5: updates during an in-flight access change nothing on the bus
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (rst)
        (dr_update && bus_req && !bus_done && !cmd.cancel) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

endmodule

// File: tb/dbg_bus_bridge_test.sv
module dbg_bus_bridge_test;
    import dbg_bus_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int IR_W   = 5;
    localparam int CAP_W  = DATA_W + 3;
    localparam int UPD_W  = ADDR_W + 4;
    localparam logic [31:0] KEY = 32'hA5A5_0000;

    logic              clk = 1'b0;
    logic              rst;
    logic [1:0]        instr;
    logic              ir_capture, dr_capture, dr_update;
    logic [UPD_W-1:0]  dr_upd_val;
    logic              flash_locked;
    logic [IR_W-1:0]   ir_cap_val;
    logic [CAP_W-1:0]  dr_cap_val;
    logic              bus_req, bus_we;
    logic [1:0]        bus_size;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_done, bus_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_bus_bridge uut (
        .clk(clk), .rst(rst), .instr(instr), .ir_capture(ir_capture),
        .dr_capture(dr_capture), .dr_update(dr_update), .dr_upd_val(dr_upd_val),
        .flash_locked(flash_locked), .ir_cap_val(ir_cap_val), .dr_cap_val(dr_cap_val),
        .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done), .bus_err(bus_err)
    );

    // Bus slave model
    int          lat = 2;
    int          cnt = 0;
    int          req_cnt = 0;
    int          wr_cnt = 0;
    logic        req_d = 1'b0;
    logic [31:0] last_waddr = '0;
    logic [31:0] last_wdata = '0;
    logic [1:0]  last_wsize = '0;

    assign bus_rdata = bus_addr ^ KEY;

    always @(posedge clk) begin
        if (rst) begin
            cnt      <= 0;
            bus_done <= 1'b0;
            bus_err  <= 1'b0;
            req_d    <= 1'b0;
        end else begin
            req_d    <= bus_req;
            bus_done <= bus_req && !bus_done && (cnt == lat - 1);
            bus_err  <= bus_req && !bus_done && (cnt == lat - 1) && (bus_addr[31:28] == 4'hF);
            cnt      <= (bus_req && !bus_done) ? cnt + 1 : 0;
            if (bus_req && !req_d) req_cnt <= req_cnt + 1;
            if (bus_req && bus_done && bus_we) begin
                wr_cnt     <= wr_cnt + 1;
                last_waddr <= bus_addr;
                last_wdata <= bus_wdata;
                last_wsize <= bus_size;
            end
        end
    end

    // Scoreboard queues
    logic [CAP_W-1:0] dr_exp_q[$];
    string            dr_tag_q[$];
    logic [IR_W-1:0]  ir_exp_q[$];
    string            ir_tag_q[$];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares captured values against queued expectations
    logic dr_s, ir_s;
    initial begin
        forever begin
            @(posedge clk);
            dr_s = dr_capture;
            ir_s = ir_capture;
            @(negedge clk);
            if (dr_s) begin
                if (dr_exp_q.size() == 0) check("R2 unexpected DR capture", 64'(dr_cap_val), 64'hDEAD);
                else check(dr_tag_q.pop_front(), 64'(dr_cap_val), 64'(dr_exp_q.pop_front()));
            end
            if (ir_s) begin
                if (ir_exp_q.size() == 0) check("R2 unexpected IR capture", 64'(ir_cap_val), 64'hDEAD);
                else check(ir_tag_q.pop_front(), 64'(ir_cap_val), 64'(ir_exp_q.pop_front()));
            end
        end
    end

    function automatic logic [CAP_W-1:0] mk(input logic [31:0] d, input logic p, input logic e, input logic b);
        return {d, p, e, b};
    endfunction

    function automatic logic [UPD_W-1:0] av(input logic [31:0] a, input logic inc, input logic [1:0] sz, input logic rd);
        return {a, inc, sz, rd};
    endfunction

    // Drivers: entered at a falling edge, leave at the next falling edge
    task automatic pulse_upd(input logic [1:0] ins, input logic [UPD_W-1:0] v);
        instr = ins; dr_update = 1'b1; dr_upd_val = v;
        @(negedge clk);
        dr_update = 1'b0;
    endtask

    task automatic cap_dr(input logic [1:0] ins, input logic [CAP_W-1:0] e, input string tag);
        instr = ins; dr_exp_q.push_back(e); dr_tag_q.push_back(tag); dr_capture = 1'b1;
        @(negedge clk);
        dr_capture = 1'b0;
    endtask

    task automatic cap_ir(input logic [IR_W-1:0] e, input string tag);
        ir_exp_q.push_back(e); ir_tag_q.push_back(tag); ir_capture = 1'b1;
        @(negedge clk);
        ir_capture = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        finish_run();
    end

    int req0, wr0;

    initial begin
        rst = 1'b1; instr = INS_NONE; ir_capture = 0; dr_capture = 0; dr_update = 0;
        dr_upd_val = '0; flash_locked = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 bus_req after reset", 64'(bus_req), 64'd0);
        cap_ir(5'b00010, "R1 IR status after reset");
        cap_dr(INS_NONE, mk(32'h0, 1'b0, 1'b1, 1'b0), "R2 DR status after reset");

        // R3 R4 read launched by address scan, busy capture
        lat = 6;
        req0 = req_cnt;
        pulse_upd(INS_ADDR, av(32'h100, 1'b1, 2'd2, 1'b1));
        cap_dr(INS_DATA, mk(32'h0, 1'b0, 1'b0, 1'b1), "R4 busy read capture");
        wait_n(10);
        cap_dr(INS_DATA, mk(32'h100 ^ KEY, 1'b0, 1'b0, 1'b0), "R3 read data at 0x100");
        check("R3 one request issued", 64'(req_cnt - req0), 64'd1);

        // R8 R9 block read continues at next word
        lat = 2;
        pulse_upd(INS_DATA, '0);
        wait_n(6);
        cap_dr(INS_DATA, mk(32'h104 ^ KEY, 1'b0, 1'b0, 1'b0), "R8 block read at 0x104");

        // R9 R8 byte block writes
        req0 = req_cnt; wr0 = wr_cnt;
        pulse_upd(INS_ADDR, av(32'h200, 1'b1, 2'd0, 1'b0));
        wait_n(3);
        check("R3 write address scan makes no request", 64'(req_cnt - req0), 64'd0);
        pulse_upd(INS_DATA, UPD_W'(32'hAB));
        wait_n(6);
        check("R9 write count", 64'(wr_cnt - wr0), 64'd1);
        check("R9 write address", 64'(last_waddr), 64'h200);
        check("R9 write data", 64'(last_wdata), 64'hAB);
        check("R9 write size byte", 64'(last_wsize), 64'd0);
        pulse_upd(INS_DATA, UPD_W'(32'hCD));
        wait_n(6);
        check("R8 byte increment address", 64'(last_waddr), 64'h201);
        check("R9 second write data", 64'(last_wdata), 64'hCD);

        // R5 update while busy is discarded
        lat = 8; wr0 = wr_cnt;
        pulse_upd(INS_DATA, UPD_W'(32'h11));
        pulse_upd(INS_DATA, UPD_W'(32'h22));
        cap_dr(INS_DATA, mk(32'h0, 1'b0, 1'b0, 1'b1), "R4 busy during write");
        wait_n(12);
        check("R5 only one write", 64'(wr_cnt - wr0), 64'd1);
        check("R5 kept first data", 64'(last_wdata), 64'h11);
        check("R5 address of kept write", 64'(last_waddr), 64'h202);

        // R6 failing read, R3 error untouched by write address scan, R7 acceptance
        lat = 2;
        pulse_upd(INS_ADDR, av(32'hF000_0000, 1'b0, 2'd2, 1'b1));
        wait_n(6);
        cap_dr(INS_DATA, mk(32'h0, 1'b0, 1'b1, 1'b0), "R6 failed read zero data and error");
        req0 = req_cnt; wr0 = wr_cnt;
        pulse_upd(INS_ADDR, av(32'h300, 1'b0, 2'd2, 1'b0));
        wait_n(3);
        check("R3 no request for write address", 64'(req_cnt - req0), 64'd0);
        cap_dr(INS_NONE, mk(32'h0, 1'b0, 1'b1, 1'b0), "R3 error unchanged by address scan");
        pulse_upd(INS_DATA, UPD_W'(32'h5555));
        cap_dr(INS_DATA, mk(32'h0, 1'b0, 1'b0, 1'b1), "R7 write accepted after error");
        wait_n(6);
        check("R7 write done", 64'(wr_cnt - wr0), 64'd1);
        check("R7 write address", 64'(last_waddr), 64'h300);
        check("R7 write data", 64'(last_wdata), 64'h5555);

        // R8 stream writes stay at one address, failing each time
        wr0 = wr_cnt;
        pulse_upd(INS_ADDR, av(32'hF000_0010, 1'b0, 2'd2, 1'b0));
        pulse_upd(INS_DATA, UPD_W'(32'h1));
        wait_n(6);
        cap_dr(INS_NONE, mk(32'h0, 1'b0, 1'b1, 1'b0), "R6 write error reported");
        pulse_upd(INS_DATA, UPD_W'(32'h2));
        wait_n(6);
        check("R7 second stream write accepted", 64'(wr_cnt - wr0), 64'd2);
        check("R8 stream address fixed", 64'(last_waddr), 64'hF000_0010);
        pulse_upd(INS_ADDR, av(32'h400, 1'b0, 2'd2, 1'b1));
        wait_n(6);
        cap_dr(INS_DATA, mk(32'h400 ^ KEY, 1'b0, 1'b0, 1'b0), "R7 read after error");

        // R10 protected
        flash_locked = 1'b1;
        cap_ir(5'b00100, "R10 IR protected flag");
        req0 = req_cnt;
        pulse_upd(INS_ADDR, av(32'h500, 1'b0, 2'd2, 1'b1));
        cap_dr(INS_DATA, mk(32'h0, 1'b1, 1'b0, 1'b1), "R10 locked access busy");
        cap_dr(INS_DATA, mk(32'h0, 1'b1, 1'b1, 1'b0), "R10 locked access failed");
        wait_n(3);
        check("R10 no bus request while locked", 64'(req_cnt - req0), 64'd0);
        flash_locked = 1'b0;

        // R11 cancel of a slow access
        lat = 20;
        pulse_upd(INS_ADDR, av(32'h600, 1'b0, 2'd2, 1'b1));
        cap_dr(INS_CANCEL, mk(32'h0, 1'b0, 1'b0, 1'b1), "R11 cancel poll sees busy");
        cap_dr(INS_NONE, mk(32'h0, 1'b0, 1'b1, 1'b0), "R11 error after cancel");
        check("R11 request dropped", 64'(bus_req), 64'd0);
        wait_n(4);
        check("R12 request stays low after cancel", 64'(bus_req), 64'd0);

        // R11 cancel coinciding with completion
        lat = 2;
        pulse_upd(INS_ADDR, av(32'h700, 1'b1, 2'd2, 1'b1));
        wait_n(6);
        cap_dr(INS_DATA, mk(32'h700 ^ KEY, 1'b0, 1'b0, 1'b0), "R8 block read at 0x700");
        pulse_upd(INS_DATA, '0);
        wait_n(2);
        cap_dr(INS_CANCEL, mk(32'h0, 1'b0, 1'b0, 1'b1), "R11 cancel on done edge sees busy");
        cap_dr(INS_DATA, mk(32'h700 ^ KEY, 1'b0, 1'b1, 1'b0), "R11 cancel wins, data not latched");
        pulse_upd(INS_DATA, '0);
        wait_n(6);
        cap_dr(INS_DATA, mk(32'h704 ^ KEY, 1'b0, 1'b0, 1'b0), "R11 address not advanced");

        wait_n(3);
        check("R2 all captures compared", 64'(dr_exp_q.size() + ir_exp_q.size()), 64'd0);
        finish_run();
    end

endmodule